// File: doc/BRIEF.md
# Floating-Point Round-and-Pack Unit

This block is the last stage of a floating-point datapath. It receives a result in an internal unpacked form: a 2-bit class, a sign, a signed unbiased exponent and a 56-bit mantissa. In that mantissa the leading one sits at bit 55 and bits 2..0 are the guard, round and sticky bits. The block rounds the value under one of four rounding modes and packs it into an IEEE-754 double-precision word. With the word it reports inexact, overflow and underflow flags for that result.

Normal results are rounded in place. A rounding carry out of the mantissa renormalises the result. A biased exponent that reaches the top code gives either infinity or the largest finite value, depending on the guard bit. Results whose biased exponent is zero or negative are first shifted right by the exponent deficit and then rounded by a second rounder, which gives denormals, a carry up to the smallest normal, or a flush to zero. Zero, NaN and infinity inputs pack to fixed encodings. The result, its flags and a valid strobe are registered and appear one clock after the input strobe. The flags describe that result only and do not accumulate.

Top module: `rnd_pack_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Word and flags load only on a strobe and otherwise hold. Reset clears every output to zero.
- R2: Rounding mode 00 is round-to-nearest-even. When the guard bit (mantissa bit 2) is set, it adds 8 if bit 1, bit 0 or the LSB (bit 3) is set. Otherwise the mantissa is unchanged.
- R3: Rounding mode 01 (toward zero) never changes the mantissa.
- R4: Rounding mode 10 (toward +inf) adds 8 when the sign is 0 and bits 2..0 are nonzero. Mode 11 (toward -inf) does the same when the sign is 1.
- R5: `out_inexact` is high when the rounder sees a nonzero value in bits 2..0, on both the normal and the denormal path. It is low for special classes and for a flush to zero.
- R6: Class 00 (normal) with biased exponent (exp+1023) > 0: when rounding carries into bit 56, the exponent rises by one and the fraction is taken from bits 55..4. Without a carry it is taken from bits 54..3.
- R7: If the biased exponent after R6 is 2047 or more and the guard bit was set before rounding, the word is infinity and `out_overflow` is high.
- R8: If the biased exponent after R6 is 2047 or more and the guard bit was clear, the word saturates to exponent 2046 with an all-ones fraction and `out_overflow` stays low.
- R9: With biased exponent b <= 0 and shift s = 1-b <= 56, the mantissa is shifted right by s, rounded and doubled. Without a carry into bit 56 the word is a denormal: exponent 0, fraction = doubled value bits 55..4, and `out_underflow` is high.
- R10: On the denormal path, a carry into bit 56 after doubling gives exponent 1 with a zero fraction and `out_underflow` low.
- R11: A shift s greater than 56 flushes the word to signed zero with `out_underflow` high.
- R12: Class 01 (zero) packs exponent 0 and fraction 0. Class 10 (NaN) packs exponent 2047 and fraction 1. Class 11 (infinity) packs exponent 2047 and fraction 0. All flags are low for these classes.
- R13: Bit 63 of the word always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_class | input | 2 | 00 normal, 01 zero, 10 NaN, 11 infinity |
| in_sign | input | 1 | Sign of the operand |
| in_exp | input | 13 | Signed unbiased exponent (two's complement) |
| in_mant | input | 56 | Mantissa, leading one at bit 55, guard/round/sticky at bits 2..0 |
| in_rmode | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 64 | Packed double-precision word |
| out_inexact | output | 1 | Result was rounded |
| out_overflow | output | 1 | Result overflowed to infinity |
| out_underflow | output | 1 | Result is denormal or flushed to zero |

## Verification
The hardest cases to reach are the two rounding carries. A carry on the normal path at exponent 1023 decides between infinity and saturation. A carry on the denormal path at a shift of one gives exponent 1. Both need a mantissa that is all ones above the rounding bits, with exactly the right guard, round, sticky and sign pattern for the chosen mode. The stimulus crosses an all-ones mantissa and an alternating mantissa with all sixteen low-nibble values, all four modes and both signs, at exponents around each boundary. It also sweeps the denormal shift from 1 through 60, so that every carry, saturation and flush case occurs.

// File: rtl/rnp_pkg.sv
package rnp_pkg;

  typedef enum logic [1:0] {
    CLS_NORM = 2'b00,
    CLS_ZERO = 2'b01,
    CLS_NAN  = 2'b10,
    CLS_INF  = 2'b11
  } fp_class_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

endpackage

// File: rtl/rnp_rounder.sv
module rnp_rounder
  import rnp_pkg::*;
#(
  parameter int W = 57
) (
  input  logic [W-1:0] m_in,
  input  logic         sign,
  input  rmode_e       mode,
  output logic [W-1:0] m_out,
  output logic         inexact
);

  logic any_low;
  logic bump;

  always_comb begin
    any_low = |m_in[2:0];
    unique case (mode)
      RM_NEAREST: bump = m_in[2] & ((|m_in[1:0]) | m_in[3]);
      RM_ZERO:    bump = 1'b0;
      RM_UP:      bump = ~sign & any_low;
      RM_DOWN:    bump = sign & any_low;
      default:    bump = 1'b0;
    endcase
    inexact = any_low;
    m_out   = m_in + (bump ? W'(8) : W'(0));
  end

  // R5: an exact operand must leave the rounder unchanged
  always_comb begin
    if (inexact == 1'b0) begin
      assert_exact_kept_R5: assert (m_out == m_in);
    end
  end

endmodule

// File: rtl/rnp_norm_path.sv
module rnp_norm_path
  import rnp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int BE_W   = 15,
  localparam int MANT_W = FRAC_W + 4
) (
  input  logic signed [BE_W-1:0]   be,
  input  logic        [MANT_W-1:0] mant,
  input  logic                     sign,
  input  rmode_e                   mode,
  output logic        [EXP_W-1:0]  exp_o,
  output logic        [FRAC_W-1:0] frac_o,
  output logic                     inexact,
  output logic                     overflow
);

  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [BE_W-1:0] EXP_MAX_S = BE_W'(EXP_MAX);

  logic [MANT_W:0]        pre;
  logic [MANT_W:0]        post;
  logic                   carry;
  logic                   guard;
  logic signed [BE_W-1:0] be_adj;
  logic [FRAC_W-1:0]      frac_sh;
  logic                   unused_low_bits;

  assign pre = {1'b0, mant};

  rnp_rounder #(.W(MANT_W + 1)) i_rnd (
    .m_in    (pre),
    .sign    (sign),
    .mode    (mode),
    .m_out   (post),
    .inexact (inexact)
  );

  assign unused_low_bits = ^post[2:0];

  always_comb begin
    carry   = post[MANT_W];
    guard   = mant[2];
    be_adj  = be + $signed({{(BE_W-1){1'b0}}, carry});
    frac_sh = carry ? post[FRAC_W+3:4] : post[FRAC_W+2:3];
    if (be_adj >= EXP_MAX_S) begin
      if (guard) begin
        exp_o    = '1;
        frac_o   = '0;
        overflow = 1'b1;
      end else begin
        exp_o    = EXP_W'(EXP_MAX - 1);
        frac_o   = '1;
        overflow = 1'b0;
      end
    end else begin
      exp_o    = be_adj[EXP_W-1:0];
      frac_o   = frac_sh;
      overflow = 1'b0;
    end
  end

endmodule

// File: rtl/rnp_denorm_path.sv
module rnp_denorm_path
  import rnp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int BE_W   = 15,
  localparam int MANT_W = FRAC_W + 4
) (
  input  logic signed [BE_W-1:0]   be,
  input  logic        [MANT_W-1:0] mant,
  input  logic                     sign,
  input  rmode_e                   mode,
  output logic        [EXP_W-1:0]  exp_o,
  output logic        [FRAC_W-1:0] frac_o,
  output logic                     inexact,
  output logic                     underflow
);

  localparam int SH_W = $clog2(MANT_W + 1);

  logic [BE_W-1:0]   sh;
  logic              flush;
  logic [MANT_W-1:0] shifted;
  logic [MANT_W-1:0] post;
  logic              rnd_nx;
  logic              unused_low_bits;

  assign sh      = BE_W'(1) - $unsigned(be);
  assign flush   = (sh > BE_W'(MANT_W));
  assign shifted = mant >> sh[SH_W-1:0];

  rnp_rounder #(.W(MANT_W)) i_rnd (
    .m_in    (shifted),
    .sign    (sign),
    .mode    (mode),
    .m_out   (post),
    .inexact (rnd_nx)
  );

  assign unused_low_bits = ^post[2:0];

  // Doubling the rounded value moves bit MANT_W-1 to the carry position.
  always_comb begin
    if (flush) begin
      exp_o     = '0;
      frac_o    = '0;
      inexact   = 1'b0;
      underflow = 1'b1;
    end else if (post[MANT_W-1]) begin
      exp_o     = EXP_W'(1);
      frac_o    = '0;
      inexact   = rnd_nx;
      underflow = 1'b0;
    end else begin
      exp_o     = '0;
      frac_o    = post[FRAC_W+2:3];
      inexact   = rnd_nx;
      underflow = 1'b1;
    end
  end

endmodule

// File: rtl/rnd_pack_unit.sv
module rnd_pack_unit
  import rnp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int IEXP_W = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [1:0]                  in_class,
  input  logic                        in_sign,
  input  logic [IEXP_W-1:0]           in_exp,
  input  logic [FRAC_W+3:0]           in_mant,
  input  logic [1:0]                  in_rmode,
  output logic                        out_valid,
  output logic [EXP_W+FRAC_W:0]       out_word,
  output logic                        out_inexact,
  output logic                        out_overflow,
  output logic                        out_underflow
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int BE_W   = IEXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  fp_class_e              cls;
  rmode_e                 rmode;
  logic signed [BE_W-1:0] be_c;
  logic                   use_norm;

  logic [EXP_W-1:0]  n_exp, d_exp, exp_d;
  logic [FRAC_W-1:0] n_frac, d_frac, frac_d;
  logic              n_nx, n_ox, d_nx, d_ux;
  logic              nx_d, ox_d, ux_d;
  logic [WORD_W-1:0] word_d;

  logic              valid_q;
  logic [WORD_W-1:0] word_q;
  logic              nx_q, ox_q, ux_q;

  assign cls      = fp_class_e'(in_class);
  assign rmode    = rmode_e'(in_rmode);
  assign be_c     = BE_W'($signed(in_exp)) + BE_W'(BIAS);
  assign use_norm = (be_c > 0);

  rnp_norm_path #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BE_W(BE_W)) i_norm (
    .be       (be_c),
    .mant     (in_mant),
    .sign     (in_sign),
    .mode     (rmode),
    .exp_o    (n_exp),
    .frac_o   (n_frac),
    .inexact  (n_nx),
    .overflow (n_ox)
  );

  rnp_denorm_path #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BE_W(BE_W)) i_denorm (
    .be        (be_c),
    .mant      (in_mant),
    .sign      (in_sign),
    .mode      (rmode),
    .exp_o     (d_exp),
    .frac_o    (d_frac),
    .inexact   (d_nx),
    .underflow (d_ux)
  );

  // next-state
  always_comb begin
    exp_d  = '0;
    frac_d = '0;
    nx_d   = 1'b0;
    ox_d   = 1'b0;
    ux_d   = 1'b0;
    unique case (cls)
      CLS_NORM: begin
        if (use_norm) begin
          exp_d  = n_exp;
          frac_d = n_frac;
          nx_d   = n_nx;
          ox_d   = n_ox;
        end else begin
          exp_d  = d_exp;
          frac_d = d_frac;
          nx_d   = d_nx;
          ux_d   = d_ux;
        end
      end
      CLS_ZERO: begin
        exp_d  = '0;
        frac_d = '0;
      end
      CLS_NAN: begin
        exp_d  = '1;
        frac_d = FRAC_W'(1);
      end
      CLS_INF: begin
        exp_d  = '1;
        frac_d = '0;
      end
      default: begin
        exp_d  = '0;
        frac_d = '0;
      end
    endcase
    word_d = {in_sign, exp_d, frac_d};
  end

  // registers: valid every cycle, payload under the strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      nx_q    <= 1'b0;
      ox_q    <= 1'b0;
      ux_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        word_q <= word_d;
        nx_q   <= nx_d;
        ox_q   <= ox_d;
        ux_q   <= ux_d;
      end
    end
  end

  assign out_valid     = valid_q;
  assign out_word      = word_q;
  assign out_inexact   = nx_q;
  assign out_overflow  = ox_q;
  assign out_underflow = ux_q;

  assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word)));

  assert_sign_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[WORD_W-1] == $past(in_sign)));

  assert_overflow_is_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |->
      ((out_word[WORD_W-2:FRAC_W] == '1) && (out_word[FRAC_W-1:0] == '0) && !out_underflow));

  assert_underflow_exp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_word[WORD_W-2:FRAC_W] == '0));

  assert_special_no_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_class != 2'b00)) |=> (!out_inexact && !out_overflow && !out_underflow));

endmodule

// File: tb/test_rnd_pack_unit.sv
module test_rnd_pack_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_class;
  logic        in_sign;
  logic [12:0] in_exp;
  logic [55:0] in_mant;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [63:0] out_word;
  logic        out_inexact;
  logic        out_overflow;
  logic        out_underflow;

  int checks = 0;
  int errors = 0;

  rnd_pack_unit i_rnd_pack_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_class      (in_class),
    .in_sign       (in_sign),
    .in_exp        (in_exp),
    .in_mant       (in_mant),
    .in_rmode      (in_rmode),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .out_inexact   (out_inexact),
    .out_overflow  (out_overflow),
    .out_underflow (out_underflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // increment decision from R2, R3, R4 on the low nibble (lsb, guard, round, sticky)
  function automatic bit bump(input logic [3:0] lo, input logic s, input logic [1:0] md);
    case (md)
      2'd0:    return lo[2] && ((lo[1:0] != 2'b00) || lo[3]);
      2'd1:    return 1'b0;
      2'd2:    return !s && (lo[2:0] != 3'b000);
      default: return s && (lo[2:0] != 3'b000);
    endcase
  endfunction

  function automatic void ref_model(input logic [1:0] c, input logic s, input int e,
                                    input logic [55:0] m, input logic [1:0] md,
                                    output logic [63:0] w, output logic nx,
                                    output logic ox, output logic ux, output string tag);
    logic [56:0] x;
    logic [10:0] ef;
    logic [51:0] fr;
    logic        g;
    int          be;
    int          sh;
    nx = 0; ox = 0; ux = 0; ef = '0; fr = '0; tag = "R12";
    case (c)
      2'd1: begin ef = '0; fr = '0; end
      2'd2: begin ef = 11'h7FF; fr = 52'd1; end
      2'd3: begin ef = 11'h7FF; fr = '0; end
      default: begin
        be = e + 1023;
        if (be > 0) begin
          g  = m[2];
          x  = {1'b0, m};
          nx = |x[2:0];
          if (bump(x[3:0], s, md)) x = x + 57'd8;
          if (md == 2'd0) tag = "R2";
          else if (md == 2'd1) tag = "R3";
          else tag = "R4";
          if (x[56]) begin be = be + 1; x = x >> 4; tag = "R6"; end
          else x = x >> 3;
          if (be >= 2047) begin
            if (g) begin ef = 11'h7FF; fr = '0; ox = 1; tag = "R7"; end
            else begin ef = 11'h7FE; fr = '1; tag = "R8"; end
          end else begin
            ef = be[10:0];
            fr = x[51:0];
          end
        end else begin
          sh = 1 - be;
          if (sh <= 56) begin
            x  = {1'b0, m} >> sh;
            nx = |x[2:0];
            if (bump(x[3:0], s, md)) x = x + 57'd8;
            x = x << 1;
            if (x[56]) begin ef = 11'd1; fr = '0; tag = "R10"; end
            else begin x = x >> 4; fr = x[51:0]; ux = 1; tag = "R9"; end
          end else begin
            ux = 1; tag = "R11";
          end
        end
      end
    endcase
    w = {s, ef, fr};
  endfunction

  task automatic run(input logic [1:0] c, input logic s, input int e,
                     input logic [55:0] m, input logic [1:0] md);
    logic [63:0] w;
    logic        nx, ox, ux;
    string       tag;
    @(negedge clk);
    in_class = c; in_sign = s; in_exp = e[12:0]; in_mant = m; in_rmode = md;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ref_model(c, s, e, m, md, w, nx, ox, ux, tag);
    chk(out_valid == 1'b1, "R1", "valid", {63'd0, out_valid}, 64'd1);
    chk(out_word == w, tag, "word", out_word, w);
    chk(out_inexact == nx, "R5", "inexact", {63'd0, out_inexact}, {63'd0, nx});
    chk(out_overflow == ox, "R7", "overflow", {63'd0, out_overflow}, {63'd0, ox});
    chk(out_underflow == ux, "R9", "underflow", {63'd0, out_underflow}, {63'd0, ux});
    chk(out_word[63] == s, "R13", "sign", {63'd0, out_word[63]}, {63'd0, s});
  endtask

  function automatic logic [55:0] pat(input int p, input logic [3:0] lo);
    if (p == 0) return {1'b1, {51{1'b1}}, lo};
    return {1'b1, {17{3'b101}}, lo};
  endfunction

  initial begin
    int elist[10] = '{-1030, -1024, -1023, -1022, 0, 7, 1022, 1023, 1024, 1500};
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_class = '0; in_sign = 1'b0;
    in_exp = '0; in_mant = '0; in_rmode = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0 && out_word == 64'd0, "R1", "reset word",
        out_word, 64'd0);
    chk({out_inexact, out_overflow, out_underflow} == 3'b000, "R1", "reset flags",
        {61'd0, out_inexact, out_overflow, out_underflow}, 64'd0);
    rst_n = 1'b1;

    // normal path and boundaries: R2 R3 R4 R6 R7 R8 R10
    foreach (elist[i]) begin
      for (int p = 0; p < 2; p++)
        for (int lo = 0; lo < 16; lo++)
          for (int md = 0; md < 4; md++)
            for (int s = 0; s < 2; s++)
              run(2'd0, s[0], elist[i], pat(p, lo[3:0]), md[1:0]);
    end

    // R1: hold while idle
    held = out_word;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "idle valid", {63'd0, out_valid}, 64'd0);
    chk(out_word == held, "R1", "idle hold", out_word, held);

    // denormal shift sweep: R9 R10 R11
    for (int sh = 1; sh <= 60; sh++)
      for (int p = 0; p < 2; p++)
        for (int md = 0; md < 4; md++)
          for (int s = 0; s < 2; s++)
            run(2'd0, s[0], -1022 - sh, pat(p, sh[3:0]), md[1:0]);

    // special classes: R12
    for (int c = 1; c < 4; c++)
      for (int md = 0; md < 4; md++)
        for (int s = 0; s < 2; s++)
          run(c[1:0], s[0], 37, pat(1, 4'h7), md[1:0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule